// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block collects six interrupt sources and reports them to a host. The sources are bit 0 and bit 3 of two parallel ports and output 1 of two counter groups. Each source has an enable bit and a sticky status bit. While a source is enabled, a rising edge on it sets its status bit. One level-sensitive request line goes to the host. It rises when the status word changes from all-zero to non-zero, and it stays high until the whole status word is zero again.

The block has no clear register. The host removes a pending status bit by writing 0 to that source's enable bit. A simple register port lets the host write the enable register and read either register. The status word is also driven out as a bank of digital inputs, one channel for each source. The source inputs are asynchronous, so each passes through a two-flop synchronizer before edge detection.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable register, the status register, the digital input bank, the request line and the read data are all zero.
- R2: A rising edge on an enabled source sets its status bit three clock edges after the source input changes (two synchronizer edges and one latch edge). The bit then appears on `din_bank` and as bit i of the status register.
- R3: An edge on a source whose enable bit is 0 is ignored, and a status bit is never 1 while its enable bit is 0.
- R4: A write of 0 to enable bit i clears status bit i at the same clock edge that takes the write. Status bits whose enable stays 1 are unaffected.
- R5: Enabling a source whose input is already high does not set its status bit. Only a later fresh rising edge does.
- R6: `irq` goes high one clock after the status word changes from zero to non-zero.
- R7: While the status word stays non-zero, `irq` stays high, including when further status bits become set.
- R8: `irq` goes low one clock after the status word returns to zero.
- R9: Address 0 selects the enable register and address 1 selects the status register. Bit i of either register belongs to source i. Bits above bit 5 read as 0. `reg_rdata` is registered and shows the selected register one clock after the address is presented.
- R10: A write to address 1 (status) changes neither the enable register nor the status register.
- R11: Only bits 5:0 of a write to the enable register are stored. A write of 0xFF reads back as 0x3F.
- R12: A status bit stays set when its source falls again. Only an enable write can clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 6 | Asynchronous interrupt source levels, bit i = source i |
| reg_addr | input | 1 | Register select: 0 enable, 1 status |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| din_bank | output | 6 | Status register presented as digital inputs |
| irq | output | 1 | Level interrupt request to the host |

## Verification
The checker checks several rules on every cycle. No status bit may be set while its enable bit is clear. A status bit may drop only in the cycle after an enable write, and only where that write carried a 0. A write to the status address must leave the enable register unchanged. The request line must track whether the status word is zero, one cycle later. The three-cycle latency from a source edge to the status bit, the refusal to latch a level that is already high when a source is re-enabled, and the read-back values through the register port can only be shown by the bench's ordered stimulus sequences.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned SRC_COUNT = 6;
  localparam int unsigned BUS_WIDTH = 8;

  typedef enum logic [0:0] {
    SEL_ENABLE = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/eirq_sync_edge.sv
module eirq_sync_edge #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] rise_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic [DEPTH-1:0] pipe_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        pipe_q <= '0;
      end else begin
        pipe_q <= {pipe_q[DEPTH-2:0], async_i[g]};
      end
    end

    // synchronized level versus its previous sample
    assign rise_o[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  input  logic [WIDTH-1:0] rise_i,
  output logic [WIDTH-1:0] en_o,
  output logic [WIDTH-1:0] st_o
);
  logic [WIDTH-1:0] en_q;
  logic [WIDTH-1:0] st_q;
  logic [WIDTH-1:0] en_d;
  logic [WIDTH-1:0] st_d;

  always_comb begin
    en_d = en_wr_i ? en_wdata_i : en_q;
    // an edge counts only if the source was enabled in that cycle;
    // a cleared enable wipes the sticky bit in the same edge
    st_d = (st_q | (rise_i & en_q)) & en_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= en_d;
      st_q <= st_d;
    end
  end

  assign en_o = en_q;
  assign st_o = st_q;
endmodule

// File: rtl/eirq_request.sv
module eirq_request #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] st_i,
  output logic             irq_o
);
  logic any_set;
  logic any_set_prev_q;
  logic irq_q;

  assign any_set = |st_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      any_set_prev_q <= 1'b0;
      irq_q          <= 1'b0;
    end else begin
      any_set_prev_q <= any_set;
      if (!any_set) begin
        irq_q <= 1'b0;
      end else if (!any_set_prev_q) begin
        irq_q <= 1'b1;
      end
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/eirq_readport.sv
module eirq_readport #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic [WIDTH-1:0]  en_i,
  input  logic [WIDTH-1:0]  st_i,
  output logic [DATA_W-1:0] rdata_o
);
  import eirq_pkg::*;

  localparam int unsigned PAD = DATA_W - WIDTH;

  logic [WIDTH-1:0]  pick;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    unique case (reg_sel_e'(sel_i))
      SEL_STATUS: pick = st_i;
      default:    pick = en_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= {{PAD{1'b0}}, pick};
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int unsigned NUM_SRC     = eirq_pkg::SRC_COUNT,
  parameter int unsigned DATA_W      = eirq_pkg::BUS_WIDTH,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_SRC-1:0] din_bank,
  output logic               irq
);
  import eirq_pkg::*;

  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] st_q;
  logic               en_wr;
  logic               wdata_unused;

  assign en_wr        = reg_wr && (reg_sel_e'(reg_addr) == SEL_ENABLE);
  assign wdata_unused = ^reg_wdata[DATA_W-1:NUM_SRC];

  eirq_sync_edge #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (src_in),
    .rise_o  (rise)
  );

  eirq_latch #(.WIDTH(NUM_SRC)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .en_wr_i    (en_wr),
    .en_wdata_i (reg_wdata[NUM_SRC-1:0]),
    .rise_i     (rise),
    .en_o       (en_q),
    .st_o       (st_q)
  );

  eirq_request #(.WIDTH(NUM_SRC)) u_req (
    .clk   (clk),
    .rst   (rst),
    .st_i  (st_q),
    .irq_o (irq)
  );

  eirq_readport #(.WIDTH(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (reg_addr),
    .en_i    (en_q),
    .st_i    (st_q),
    .rdata_o (reg_rdata)
  );

  assign din_bank = st_q;
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned DATA_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_addr,
  input logic               reg_wr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [NUM_SRC-1:0] enable_q,
  input logic [NUM_SRC-1:0] status_q,
  input logic               irq
);
  logic en_write;
  logic st_write;
  assign en_write = reg_wr && (reg_addr == 1'b0);
  assign st_write = reg_wr && (reg_addr == 1'b1);

  // R3
  masked_status_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~enable_q) == '0);

  // R4
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    en_write |=> (status_q & ~$past(reg_wdata[NUM_SRC-1:0])) == '0);

  // R12
  sticky_status_chk: assert property (@(posedge clk) disable iff (rst)
    !en_write |=> (status_q & $past(status_q)) == $past(status_q));

  // R10
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    st_write |=> $stable(enable_q));

  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q != '0) |=> irq);

  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q == '0) |=> !irq);
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .enable_q  (en_q),
  .status_q  (st_q),
  .irq       (irq)
);

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;
  localparam int unsigned N  = 6;
  localparam int unsigned DW = 8;
  localparam int unsigned NV = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_in = '0;
  logic          reg_addr = 1'b0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [N-1:0]  din_bank;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .src_in(src_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .din_bank(din_bank), .irq(irq)
  );

  // {enable, sources, expected status, expected irq}
  localparam logic [18:0] VEC [NV] = '{
    {6'h3F, 6'h01, 6'h01, 1'b1},
    {6'h3F, 6'h03, 6'h03, 1'b1},
    {6'h3F, 6'h00, 6'h03, 1'b1},
    {6'h3E, 6'h00, 6'h02, 1'b1},
    {6'h3C, 6'h00, 6'h00, 1'b0},
    {6'h3C, 6'h30, 6'h30, 1'b1},
    {6'h0C, 6'h3C, 6'h0C, 1'b1},
    {6'h3F, 6'h3C, 6'h0C, 1'b1},
    {6'h00, 6'h00, 6'h00, 1'b0},
    {6'h00, 6'h3F, 6'h00, 1'b0},
    {6'h3F, 6'h3F, 6'h00, 1'b0},
    {6'h3F, 6'h00, 6'h00, 1'b0},
    {6'h3F, 6'h2A, 6'h2A, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [DW-1:0] d);
    reg_addr = a;
    tick(1);
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] rv;
    tick(3);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 din_bank", din_bank, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rdata", reg_rdata, 0);
    rd(1'b0, rv); chk("R1 enable", rv, 0);

    // vector walk: R2 R3 R4 R5 R7 R12
    for (int v = 0; v < NV; v++) begin
      wr(1'b0, {2'b00, VEC[v][18:13]});
      src_in = VEC[v][12:7];
      tick(6);
      chk($sformatf("R2/R3/R4/R5/R12 vec%0d status", v), din_bank, VEC[v][6:1]);
      chk($sformatf("R7 vec%0d irq", v), irq, VEC[v][0]);
      rd(1'b1, rv);
      chk($sformatf("R9 vec%0d status read", v), rv, {2'b00, VEC[v][6:1]});
    end

    // R2/R6 exact latency; status 2A, irq high; clear everything first
    wr(1'b0, 8'h00); tick(2);
    chk("R8 cleared", irq, 0);
    wr(1'b0, 8'h01);
    src_in = 6'h00; tick(4);
    src_in = 6'h01;
    tick(2);
    chk("R2 not yet", din_bank, 0);
    tick(1);
    chk("R2 latched", din_bank, 6'h01);
    chk("R6 not yet", irq, 0);
    tick(1);
    chk("R6 raised", irq, 1);

    // R7 extra bit keeps irq high
    wr(1'b0, 8'h03);
    src_in = 6'h03;
    for (int k = 0; k < 5; k++) begin
      tick(1);
      chk("R7 held", irq, 1);
    end
    chk("R7 both bits", din_bank, 6'h03);

    // R4 partial clear, R8 drop latency
    wr(1'b0, 8'h01);
    chk("R4 partial", din_bank, 6'h01);
    chk("R7 still high", irq, 1);
    wr(1'b0, 8'h00);
    chk("R4 full clear", din_bank, 0);
    chk("R8 one cycle lag", irq, 1);
    tick(1);
    chk("R8 dropped", irq, 0);

    // R10 status write ignored
    wr(1'b0, 8'h15);
    wr(1'b1, 8'hFF);
    rd(1'b0, rv); chk("R10 enable unchanged", rv, 8'h15);
    rd(1'b1, rv); chk("R10 status unchanged", rv, 8'h00);

    // R11 upper bits dropped
    wr(1'b0, 8'hFF);
    rd(1'b0, rv); chk("R11 readback", rv, 8'h3F);

    // R9 rdata registered: switch address, value follows one clock later
    src_in = 6'h00; tick(4);
    src_in = 6'h20; tick(4);
    reg_addr = 1'b0; tick(1);
    reg_addr = 1'b1; #1;
    chk("R9 still enable", reg_rdata, 8'h3F);
    tick(1);
    chk("R9 status", reg_rdata, 8'h20);

    done = 1'b1;
    finish_run();
  end
endmodule